// File: doc/BRIEF.md
# Dual-Ring Rule-30 Random Word Generator

This block delivers one 8-bit pseudo-random word per enabled clock. Inside it, two one-dimensional cellular automata run side by side. Each automaton has two states per cell and updates under Rule 30. Each automaton is closed into a ring. The two rings have different lengths, 23 and 17 cells by default.

Eight evenly spaced cells are picked from each ring. The two 8-bit picks are XORed bit by bit to form the output word. A single Rule-30 automaton gives a skewed distribution of words, and mixing two rings of unequal length flattens it. A typical user is a comparator that turns a probability into a stochastic bit stream.

A synchronous reset seeds each ring with a single 1 in its middle cell. While enable is low, the whole block holds its state.

Top module: `ca30_rng`

## Requirements
- R1: While `rst` is high at a rising edge, `rnd_o` becomes 0 at that edge.
- R2: Every cell updates at the same edge. Its new value is bit {left,self,right} of the code 8'b00011110 (decimal 30). Here left is the cell with the next higher index and right is the one with the next lower index. So patterns 111, 110, 101 and 000 give 0, and 100, 011, 010 and 001 give 1.
- R3: Each ring wraps around. The right neighbour of cell 0 is cell N-1, and the left neighbour of cell N-1 is cell 0.
- R4: Reset loads ring A (N=23) and ring B (N=17) each with a single 1 at cell index N/2 (11 and 8), and all other cells 0.
- R5: Output bit k (k = 0..7) of a ring's pick is the cell at index floor(k*N/8). For A these are 0,2,5,8,11,14,17,20. For B they are 0,2,4,6,8,10,12,14.
- R6: `rnd_o` equals the bitwise XOR of the pick from ring A and the pick from ring B.
- R7: At an edge where `en` is low and `rst` is low, neither the rings nor `rnd_o` change.
- R8: `rnd_o` is registered. After the k-th enabled edge since reset, it shows the pick of the ring states after k updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset and seed load |
| en | input | 1 | Advance both rings by one step |
| rnd_o | output | 8 | Registered random word |

## Verification
A wrong rule bit, a wrong neighbour index or a missing wrap corrupts some cell after a single step. That damage spreads by one cell per enabled cycle. Within at most half a ring length of steps, it reaches a tapped cell and shows up as a wrong `rnd_o` bit. Comparing every enabled cycle against an independent model, over hundreds of steps, therefore exposes any such fault.

A wrong seed or wrong tap position shows within the first few words. A broken hold shows on the first cycle with enable low.

// File: rtl/ca30_pkg.sv
package ca30_pkg;

  // Next-state code, indexed by {left, self, right}
  localparam logic [7:0] RULE_CODE = 8'd30;

  // Index of the cell feeding output bit k in a ring of n cells and w taps
  function automatic int tap_pos(input int k, input int n, input int w);
    return (k * n) / w;
  endfunction

endpackage

// File: rtl/ca30_ring.sv
module ca30_ring #(
  parameter int CELLS    = 23,
  parameter int SEED_POS = CELLS / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [CELLS-1:0] state_o,
  output logic [CELLS-1:0] next_o
);
  localparam logic [CELLS-1:0] SEED = {{(CELLS-1){1'b0}}, 1'b1} << SEED_POS;

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    localparam int LI = (i + 1) % CELLS;
    localparam int RI = (i + CELLS - 1) % CELLS;
    assign next_o[i] = ca30_pkg::RULE_CODE[{state_o[LI], state_o[i], state_o[RI]}];
  end

  always_ff @(posedge clk) begin
    if (rst)     state_o <= SEED;
    else if (en) state_o <= next_o;
  end
endmodule

// File: rtl/ca30_tap.sv
module ca30_tap #(
  parameter int CELLS = 23,
  parameter int OUT_W = 8
) (
  input  logic [CELLS-1:0] state_i,
  output logic [OUT_W-1:0] taps_o
);
  for (genvar k = 0; k < OUT_W; k++) begin : g_tap
    localparam int P = ca30_pkg::tap_pos(k, CELLS, OUT_W);
    assign taps_o[k] = state_i[P];
  end
endmodule

// File: rtl/ca30_rng.sv
module ca30_rng #(
  parameter int CELLS_A = 23,
  parameter int CELLS_B = 17,
  parameter int OUT_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [OUT_W-1:0] rnd_o
);
  logic [CELLS_A-1:0] st_a, nx_a;
  logic [CELLS_B-1:0] st_b, nx_b;
  logic [OUT_W-1:0]   pick_a, pick_b;

  ca30_ring #(.CELLS(CELLS_A)) i_ring_a (
    .clk(clk), .rst(rst), .en(en), .state_o(st_a), .next_o(nx_a));
  ca30_ring #(.CELLS(CELLS_B)) i_ring_b (
    .clk(clk), .rst(rst), .en(en), .state_o(st_b), .next_o(nx_b));

  ca30_tap #(.CELLS(CELLS_A), .OUT_W(OUT_W)) i_tap_a (.state_i(nx_a), .taps_o(pick_a));
  ca30_tap #(.CELLS(CELLS_B), .OUT_W(OUT_W)) i_tap_b (.state_i(nx_b), .taps_o(pick_b));

  // Output follows the state the rings move into at the same edge
  always_ff @(posedge clk) begin
    if (rst)     rnd_o <= '0;
    else if (en) rnd_o <= pick_a ^ pick_b;
  end
endmodule

// File: rtl/ca30_chk.sv
module ca30_chk #(
  parameter int CELLS_A = 23,
  parameter int CELLS_B = 17,
  parameter int OUT_W   = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               en,
  input logic [OUT_W-1:0]   rnd_o,
  input logic [CELLS_A-1:0] st_a,
  input logic [CELLS_B-1:0] st_b
);
  localparam logic [CELLS_A-1:0] SEED_A = {{(CELLS_A-1){1'b0}}, 1'b1} << (CELLS_A / 2);
  localparam logic [CELLS_B-1:0] SEED_B = {{(CELLS_B-1){1'b0}}, 1'b1} << (CELLS_B / 2);

  function automatic logic [OUT_W-1:0] mix(input logic [CELLS_A-1:0] a,
                                           input logic [CELLS_B-1:0] b);
    logic [OUT_W-1:0] r;
    for (int k = 0; k < OUT_W; k++)
      r[k] = a[ca30_pkg::tap_pos(k, CELLS_A, OUT_W)] ^ b[ca30_pkg::tap_pos(k, CELLS_B, OUT_W)];
    return r;
  endfunction

  assert_clear_R1: assert property (@(posedge clk) rst |=> rnd_o == '0);

  assert_seed_R4: assert property (@(posedge clk) rst |=> (st_a == SEED_A && st_b == SEED_B));

  assert_wrap_low_R3: assert property (@(posedge clk) disable iff (rst)
    en |=> st_a[0] == ca30_pkg::RULE_CODE[{$past(st_a[1]), $past(st_a[0]), $past(st_a[CELLS_A-1])}]);

  assert_wrap_high_R3: assert property (@(posedge clk) disable iff (rst)
    en |=> st_b[CELLS_B-1] == ca30_pkg::RULE_CODE[{$past(st_b[0]), $past(st_b[CELLS_B-1]),
                                                    $past(st_b[CELLS_B-2])}]);

  assert_mix_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rnd_o == mix(st_a, st_b));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(rnd_o) && $stable(st_a) && $stable(st_b)));
endmodule

bind ca30_rng ca30_chk #(.CELLS_A(CELLS_A), .CELLS_B(CELLS_B), .OUT_W(OUT_W)) i_ca30_chk (
  .clk(clk), .rst(rst), .en(en), .rnd_o(rnd_o), .st_a(st_a), .st_b(st_b));

// File: tb/test_ca30_rng.sv
module test_ca30_rng;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 23;
  localparam int NB = 17;
  localparam logic [0:47] EN_PLAN = 48'b1111_0110_1011_0011_1000_1111_1101_0101_1110_0111_1111_0001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [7:0] rnd_o;
  int errors = 0;
  int checks = 0;

  logic [NA-1:0] ma;
  logic [NB-1:0] mb;
  logic [7:0]    exp_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ca30_rng i_ca30_rng (.clk(clk), .rst(rst), .en(en), .rnd_o(rnd_o));

  // R2: rule table written out by pattern
  function automatic logic rule30(input logic l, input logic c, input logic r);
    case ({l, c, r})
      3'b111, 3'b110, 3'b101, 3'b000: return 1'b0;
      default:                        return 1'b1;
    endcase
  endfunction

  function automatic logic [NA-1:0] step_a(input logic [NA-1:0] s);
    logic [NA-1:0] n;
    for (int i = 0; i < NA; i++)
      n[i] = rule30(s[(i + 1) % NA], s[i], s[(i + NA - 1) % NA]); // R3 ring wrap
    return n;
  endfunction

  function automatic logic [NB-1:0] step_b(input logic [NB-1:0] s);
    logic [NB-1:0] n;
    for (int i = 0; i < NB; i++)
      n[i] = rule30(s[(i + 1) % NB], s[i], s[(i + NB - 1) % NB]);
    return n;
  endfunction

  // R5, R6: evenly spaced picks XORed
  function automatic logic [7:0] pick(input logic [NA-1:0] a, input logic [NB-1:0] b);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = a[(k * NA) / 8] ^ b[(k * NB) / 8];
    return r;
  endfunction

  task automatic seed_model();
    ma = '0; ma[NA / 2] = 1'b1;  // R4
    mb = '0; mb[NB / 2] = 1'b1;
  endtask

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (rnd_o !== exp) begin
      errors++;
      $display("FAIL %s: rnd_o=%h expected=%h", req, rnd_o, exp);
    end
  endtask

  task automatic cyc(input logic e, input string req);
    en = e;
    @(posedge clk);
    #1;
    if (e) begin
      ma = step_a(ma);
      mb = step_b(mb);
      exp_o = pick(ma, mb);
    end
    check(req, exp_o);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    en  = 1'b1;
    @(posedge clk);
    #1;
    seed_model();
    exp_o = 8'h00;
    check("R1 reset clear", 8'h00);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R4, R8: first enabled step starts from the seed
    cyc(1'b1, "R4 R8 first step");
    // Table walk: R2, R3, R5, R6 on enabled cycles, R7 on idle ones
    for (int idx = 0; idx < 48; idx++)
      cyc(EN_PLAN[idx], EN_PLAN[idx] ? "R2 R3 R5 R6 step" : "R7 hold");
    // Reset in the middle of a run restarts the sequence (R1, R4)
    do_reset();
    for (int idx = 0; idx < 5; idx++) cyc(1'b1, "R4 R8 restart");
    // Long idle stretch: nothing moves (R7)
    for (int idx = 0; idx < 20; idx++) cyc(1'b0, "R7 long hold");
    // Long run: wrap effects reach every tap (R2, R3)
    for (int idx = 0; idx < 400; idx++) cyc(1'b1, "R2 R3 long run");
    // Reset with enable low still clears (R1)
    rst = 1'b1; en = 1'b0;
    @(posedge clk); #1;
    seed_model(); exp_o = 8'h00;
    check("R1 reset with en low", 8'h00);
    @(negedge clk); rst = 1'b0;
    for (int idx = 0; idx < 3; idx++) cyc(1'b1, "R6 after reset");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule